// File: doc/BRIEF.md
# Absolute-Indexed Bus Cycle Sequencer

This block generates the exact sequence of bus cycles for an 8-bit accumulator processor executing an instruction in absolute-indexed addressing mode on a 16-bit address bus. It supports three operation kinds: a load, a store, and a read-modify-write that increments memory. The block fetches the opcode and the two operand bytes itself. It adds the latched index to the operand base and emits, cycle by cycle, the address, the read/write strobe (1 = read) and the write data. This includes every dummy cycle the processor would place on the bus.

A policy input selects one of two dummy-cycle behaviours. In the legacy policy, every dummy read goes to the uncorrected address: the original base high byte joined with the indexed low byte. In the revised policy, a dummy cycle that follows a page crossing reads the operand high-byte address instead of any data address. A store with no crossing takes its dummy read at the real target. The block is used to drive or model the bus of a processor core, so that peripherals with side effects on read see the correct access pattern.

States: IDLE (bus parked on the program counter, waiting for a start), OPC (opcode fetch at PC), LO (read PC+1, capture base low byte), HI (read PC+2, capture base high byte), DUMMY (extra read cycle), READ (true data read), WRITE (store data write), WB_OLD (write back the unmodified value), WB_NEW (write the incremented value). Transitions: IDLE→OPC on start; OPC→LO→HI unconditionally; HI→READ for a load without carry; HI→DUMMY for a load with carry and for every store and read-modify-write; DUMMY→READ for load and read-modify-write; DUMMY→WRITE for store; READ→IDLE for load; READ→WB_OLD for read-modify-write; WB_OLD→WB_NEW; WRITE→IDLE and WB_NEW→IDLE. Every return to IDLE raises the done pulse and advances the program counter by three.

Top module: `absidx_seq`

## Requirements
- R1: After reset the block is idle. In idle it drives a read (rnw = 1) of the program counter, which resets to RESET_PC (0xFF00 by default), and done is 0. It stays there while start is low.
- R2: A start sampled in idle begins with three reads at PC, PC+1 and PC+2 in successive cycles. The bytes read at PC+1 and PC+2 are the base low and high bytes.
- R3: A load (op_kind 0, and also the unused code 3) whose indexed low byte does not carry reads the final address (base + index) in the cycle right after the PC+2 read, with no dummy cycle.
- R4: A load whose indexed low byte carries inserts one dummy read before the final read. Under the legacy policy (policy = 0) the dummy read goes to {base high byte, low byte of base low + index}.
- R5: A store (op_kind 1) always has one dummy read between the PC+2 read and its write. Under the legacy policy that read goes to {base high byte, indexed low byte}, and the write goes to base + index.
- R6: Under the revised policy (policy = 1), a store or read-modify-write without a carry takes its dummy read at the final address base + index.
- R7: Under the revised policy, any dummy cycle after a carry reads the PC+2 address (the operand high byte), for all three kinds.
- R8: A read-modify-write (op_kind 2) performs, after its dummy read, a read of the final address. It then writes the value read and then writes that value plus one (modulo 256), both to the final address.
- R9: A store writes the store_data value that was sampled with start.
- R10: In the cycle after the last data cycle, done is 1 for exactly one cycle and the idle address equals the old PC plus 3.
- R11: A start asserted while an instruction is in progress is ignored: the trace of the running instruction is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled in idle only) |
| op_kind | input | 2 | 0 load, 1 store, 2 read-modify-write, 3 load |
| policy | input | 1 | 0 legacy dummy cycles, 1 revised dummy cycles |
| index | input | 8 | Index register value, sampled with start |
| store_data | input | 8 | Value to store, sampled with start |
| din | input | 8 | Read data bus |
| bus_addr | output | 16 | Address of the current cycle |
| rnw | output | 1 | 1 = read cycle, 0 = write cycle |
| dout | output | 8 | Write data (0 on read cycles) |
| done | output | 1 | One-cycle pulse after an instruction completes |

## Verification
The bench builds the block with its defaults: 8-bit data, so a 16-bit address, and the program counter starting at 0xFF00. This keeps the PC+2 dummy address far from the 0x12xx, 0x40xx and 0x80xx data regions used by the vectors, so a revised-policy dummy read can always be told apart from a data access. Bases such as 0x80FD, 0x80FE and 0x80FF with small indices sit on either side of the page boundary. Index 0xFF with base 0x80FF gives the largest carry. Each instruction's full trace is predicted from the base, index, kind and policy and compared cycle by cycle.

// File: rtl/absidx_pkg.sv
package absidx_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_LO,
        ST_HI,
        ST_DUMMY,
        ST_READ,
        ST_WRITE,
        ST_WB_OLD,
        ST_WB_NEW
    } seq_state_e;

    localparam logic [1:0] KIND_LOAD  = 2'd0;
    localparam logic [1:0] KIND_STORE = 2'd1;
    localparam logic [1:0] KIND_RMW   = 2'd2;
endpackage

// File: rtl/absidx_operand.sv
module absidx_operand #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_idx,
    input  logic [DATA_W-1:0]     idx_in,
    input  logic                  cap_lo,
    input  logic                  cap_hi,
    input  logic [DATA_W-1:0]     din,
    output logic                  carry,
    output logic [2*DATA_W-1:0]   final_addr,
    output logic [2*DATA_W-1:0]   uncorr_addr
);
    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W:0]   sum_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            if (cap_idx) idx_q <= idx_in;
            if (cap_lo)  lo_q  <= din;
            if (cap_hi)  hi_q  <= din;
        end
    end

    always_comb begin
        sum_w       = {1'b0, lo_q} + {1'b0, idx_q};
        carry       = sum_w[DATA_W];
        uncorr_addr = {hi_q, sum_w[DATA_W-1:0]};
        final_addr  = {hi_q + {{(DATA_W-1){1'b0}}, sum_w[DATA_W]}, sum_w[DATA_W-1:0]};
    end
endmodule

// File: rtl/absidx_modify.sv
module absidx_modify #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] old_val,
    output logic [DATA_W-1:0] new_val
);
    logic [DATA_W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   val_q <= '0;
        else if (cap) val_q <= din;
    end

    assign old_val = val_q;
    assign new_val = val_q + {{(DATA_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/absidx_fsm.sv
module absidx_fsm
    import absidx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [2*DATA_W-1:0] RESET_PC = 16'hFF00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          op_kind,
    input  logic                policy,
    input  logic [DATA_W-1:0]   store_data,
    input  logic                carry,
    input  logic [2*DATA_W-1:0] final_addr,
    input  logic [2*DATA_W-1:0] uncorr_addr,
    input  logic [DATA_W-1:0]   old_val,
    input  logic [DATA_W-1:0]   new_val,
    output logic                cap_idx,
    output logic                cap_lo,
    output logic                cap_hi,
    output logic                cap_mod,
    output logic [2*DATA_W-1:0] bus_addr,
    output logic                rnw,
    output logic [DATA_W-1:0]   dout,
    output logic                done
);
    localparam int ADDR_W = 2 * DATA_W;

    seq_state_e          state_q, state_d;
    logic [1:0]          kind_q;
    logic                pol_q;
    logic [DATA_W-1:0]   sdata_q;
    logic [ADDR_W-1:0]   pc_q;
    logic                done_q;
    logic                is_store, is_rmw, last_cycle;
    logic [ADDR_W-1:0]   dummy_addr;

    assign is_store = (kind_q == KIND_STORE);
    assign is_rmw   = (kind_q == KIND_RMW);
    assign cap_idx  = (state_q == ST_IDLE) && start;

    // next state
    always_comb begin
        state_d    = state_q;
        last_cycle = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_OPC;
            ST_OPC:    state_d = ST_LO;
            ST_LO:     state_d = ST_HI;
            ST_HI: begin
                if (is_store || is_rmw || carry) state_d = ST_DUMMY;
                else                              state_d = ST_READ;
            end
            ST_DUMMY:  state_d = is_store ? ST_WRITE : ST_READ;
            ST_READ: begin
                if (is_rmw) state_d = ST_WB_OLD;
                else begin
                    state_d    = ST_IDLE;
                    last_cycle = 1'b1;
                end
            end
            ST_WRITE: begin
                state_d    = ST_IDLE;
                last_cycle = 1'b1;
            end
            ST_WB_OLD: state_d = ST_WB_NEW;
            ST_WB_NEW: begin
                state_d    = ST_IDLE;
                last_cycle = 1'b1;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and instruction context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_LOAD;
            pol_q   <= 1'b0;
            sdata_q <= '0;
            pc_q    <= RESET_PC;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= last_cycle;
            if (last_cycle) pc_q <= pc_q + ADDR_W'(3);
            if (cap_idx) begin
                kind_q  <= op_kind;
                pol_q   <= policy;
                sdata_q <= store_data;
            end
        end
    end

    assign dummy_addr = !pol_q ? uncorr_addr
                               : (carry ? pc_q + ADDR_W'(2) : final_addr);

    // outputs
    always_comb begin
        bus_addr = pc_q;
        rnw      = 1'b1;
        dout     = '0;
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        cap_mod  = 1'b0;
        unique case (state_q)
            ST_IDLE:   bus_addr = pc_q;
            ST_OPC:    bus_addr = pc_q;
            ST_LO: begin
                bus_addr = pc_q + ADDR_W'(1);
                cap_lo   = 1'b1;
            end
            ST_HI: begin
                bus_addr = pc_q + ADDR_W'(2);
                cap_hi   = 1'b1;
            end
            ST_DUMMY:  bus_addr = dummy_addr;
            ST_READ: begin
                bus_addr = final_addr;
                cap_mod  = is_rmw;
            end
            ST_WRITE: begin
                bus_addr = final_addr;
                rnw      = 1'b0;
                dout     = sdata_q;
            end
            ST_WB_OLD: begin
                bus_addr = final_addr;
                rnw      = 1'b0;
                dout     = old_val;
            end
            ST_WB_NEW: begin
                bus_addr = final_addr;
                rnw      = 1'b0;
                dout     = new_val;
            end
            default:   bus_addr = pc_q;
        endcase
    end

    assign done = done_q;

    // R3: load without carry goes straight to the data read
    assert_load_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI && !is_store && !is_rmw && !carry) |=> (state_q == ST_READ));

    // R5: a store always passes through a dummy cycle before writing
    assert_store_dummy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> ($past(state_q) == ST_DUMMY));

    // R8: the two write-backs hit the same address and follow each other
    assert_rmw_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB_OLD) |=> (state_q == ST_WB_NEW && !rnw));
    assert_rmw_same_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB_NEW) |-> (bus_addr == $past(bus_addr)));

    // R10: done lasts a single cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: no new instruction begins unless the block was idle
    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_OPC));
endmodule

// File: rtl/absidx_seq.sv
module absidx_seq #(
    parameter int DATA_W = 8,
    parameter logic [2*DATA_W-1:0] RESET_PC = 16'hFF00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          op_kind,
    input  logic                policy,
    input  logic [DATA_W-1:0]   index,
    input  logic [DATA_W-1:0]   store_data,
    input  logic [DATA_W-1:0]   din,
    output logic [2*DATA_W-1:0] bus_addr,
    output logic                rnw,
    output logic [DATA_W-1:0]   dout,
    output logic                done
);
    localparam int ADDR_W = 2 * DATA_W;

    logic              cap_idx, cap_lo, cap_hi, cap_mod, carry;
    logic [ADDR_W-1:0] final_addr, uncorr_addr;
    logic [DATA_W-1:0] old_val, new_val;

    absidx_operand #(.DATA_W(DATA_W)) u_operand (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_idx    (cap_idx),
        .idx_in     (index),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi),
        .din        (din),
        .carry      (carry),
        .final_addr (final_addr),
        .uncorr_addr(uncorr_addr)
    );

    absidx_modify #(.DATA_W(DATA_W)) u_modify (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap_mod),
        .din    (din),
        .old_val(old_val),
        .new_val(new_val)
    );

    absidx_fsm #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_kind    (op_kind),
        .policy     (policy),
        .store_data (store_data),
        .carry      (carry),
        .final_addr (final_addr),
        .uncorr_addr(uncorr_addr),
        .old_val    (old_val),
        .new_val    (new_val),
        .cap_idx    (cap_idx),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi),
        .cap_mod    (cap_mod),
        .bus_addr   (bus_addr),
        .rnw        (rnw),
        .dout       (dout),
        .done       (done)
    );
endmodule

// File: tb/absidx_seq_tb.sv
module absidx_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic        policy = 1'b0;
    logic [7:0]  index = 8'd0;
    logic [7:0]  store_data = 8'd0;
    logic [7:0]  din;
    logic [15:0] bus_addr;
    logic        rnw;
    logic [7:0]  dout;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] pc_m = 16'hFF00;
    logic [15:0] base_m = 16'h0000;

    always #2 clk = ~clk;

    absidx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .policy(policy), .index(index), .store_data(store_data), .din(din),
        .bus_addr(bus_addr), .rnw(rnw), .dout(dout), .done(done)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model: program bytes at pc..pc+2, pattern elsewhere
    always_comb begin
        if (bus_addr == pc_m)                  din = 8'h9D;
        else if (bus_addr == pc_m + 16'd1)     din = base_m[7:0];
        else if (bus_addr == pc_m + 16'd2)     din = base_m[15:8];
        else                                   din = pat(bus_addr);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // {policy, kind, base, index}
    localparam int NV = 15;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 2'd0, 16'h80FD, 8'h02},
        {1'b0, 2'd0, 16'h80FE, 8'h02},
        {1'b0, 2'd1, 16'h8000, 8'h02},
        {1'b0, 2'd1, 16'h80FE, 8'h02},
        {1'b0, 2'd2, 16'h80FD, 8'h02},
        {1'b0, 2'd2, 16'h80FF, 8'h01},
        {1'b0, 2'd0, 16'h12F0, 8'h20},
        {1'b1, 2'd0, 16'h80FD, 8'h02},
        {1'b1, 2'd0, 16'h80FE, 8'h02},
        {1'b1, 2'd1, 16'h80FD, 8'h02},
        {1'b1, 2'd1, 16'h80FE, 8'h02},
        {1'b1, 2'd2, 16'h80FE, 8'h02},
        {1'b1, 2'd2, 16'h4000, 8'h05},
        {1'b1, 2'd1, 16'h80FF, 8'hFF},
        {1'b1, 2'd3, 16'h80F0, 8'h30}
    };

    task automatic run_instr(input logic pol, input logic [1:0] kind,
                             input logic [15:0] base, input logic [7:0] idx,
                             input logic [7:0] sd, input logic hold_start);
        logic [15:0] ea [8];
        logic        er [8];
        logic [7:0]  ed [8];
        int          n;
        logic [8:0]  s9;
        logic        c;
        logic [15:0] fin, unc, dum, pc0;
        pc0 = pc_m;
        s9  = {1'b0, base[7:0]} + {1'b0, idx};
        c   = s9[8];
        fin = base + {8'h00, idx};
        unc = {base[15:8], s9[7:0]};
        dum = !pol ? unc : (c ? pc0 + 16'd2 : fin);
        ea[0] = pc0;         er[0] = 1'b1; ed[0] = 8'h00;
        ea[1] = pc0 + 16'd1; er[1] = 1'b1; ed[1] = 8'h00;
        ea[2] = pc0 + 16'd2; er[2] = 1'b1; ed[2] = 8'h00;
        n = 3;
        if (kind == 2'd1) begin
            ea[3] = dum; er[3] = 1'b1; ed[3] = 8'h00;
            ea[4] = fin; er[4] = 1'b0; ed[4] = sd;
            n = 5;
        end else if (kind == 2'd2) begin
            ea[3] = dum; er[3] = 1'b1; ed[3] = 8'h00;
            ea[4] = fin; er[4] = 1'b1; ed[4] = 8'h00;
            ea[5] = fin; er[5] = 1'b0; ed[5] = pat(fin);
            ea[6] = fin; er[6] = 1'b0; ed[6] = pat(fin) + 8'd1;
            n = 7;
        end else begin
            if (c) begin
                ea[3] = dum; er[3] = 1'b1; ed[3] = 8'h00;
                n = 4;
            end
            ea[n] = fin; er[n] = 1'b1; ed[n] = 8'h00;
            n = n + 1;
        end
        base_m = base;
        @(negedge clk);
        start = 1'b1; op_kind = kind; policy = pol; index = idx; store_data = sd;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0 && !hold_start) start = 1'b0;
            if (k == n - 1) start = 1'b0;
            // R2 R3 R4 R5 R6 R7 R8 R11: per-cycle address and direction
            check($sformatf("R2-trace addr cyc%0d pol%0d kind%0d base%h idx%h R11", k, pol, kind, base, idx),
                  {16'h0, bus_addr}, {16'h0, ea[k]});
            check($sformatf("R5 rnw cyc%0d base%h", k, base), {31'h0, rnw}, {31'h0, er[k]});
            if (!er[k])
                check($sformatf("R8 R9 write data cyc%0d base%h", k, base), {24'h0, dout}, {24'h0, ed[k]});
            check($sformatf("R10 no early done cyc%0d", k), {31'h0, done}, 32'h0);
        end
        @(negedge clk);
        check("R10 done raised", {31'h0, done}, 32'h1);
        check("R10 pc advanced", {16'h0, bus_addr}, {16'h0, pc0 + 16'd3});
        check("R1 idle read", {31'h0, rnw}, 32'h1);
        pc_m = pc0 + 16'd3;
        @(negedge clk);
        check("R10 done single pulse", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle hold
        check("R1 reset addr", {16'h0, bus_addr}, 32'h0000FF00);
        check("R1 reset rnw", {31'h0, rnw}, 32'h1);
        check("R1 reset done", {31'h0, done}, 32'h0);
        repeat (3) @(negedge clk);
        check("R1 idle hold addr", {16'h0, bus_addr}, 32'h0000FF00);

        for (int i = 0; i < NV; i++) begin
            run_instr(VEC[i][26], VEC[i][25:24], VEC[i][23:8], VEC[i][7:0],
                      8'hC0 + 8'(i), 1'b0);
        end

        // R11: start held high during a crossing read-modify-write and a store
        run_instr(1'b0, 2'd2, 16'h80FF, 8'h01, 8'h11, 1'b1);
        run_instr(1'b1, 2'd1, 16'h80FE, 8'h02, 8'h22, 1'b1);
        // R3: load with index 0 on a page's last byte (no carry)
        run_instr(1'b0, 2'd0, 16'h40FF, 8'h00, 8'h00, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule